// File: doc/BRIEF.md
# DDR SDRAM Write Burst Generator

This block sits on the controller side of a double-data-rate SDRAM interface. It turns one accepted request into a single WRITE command, aimed at a row that is already open, and then the four-beat write burst that follows it. A request holds a bank, a starting column, an auto-precharge flag, four data words and one byte mask for each word. The generator drives the command pins, the address and bank pins, the data and mask beats, and the data strobe together with output enables for each.

Each clock cycle carries two output values: one for the rising edge and one for the falling edge. A later I/O stage serialises them. The strobe sits low for one cycle before the data (the preamble) and for one cycle after it (the postamble). After that, data and strobe go back to high impedance.

Requests use a ready/valid handshake. A new request may be accepted in the last data cycle of the current burst. Its WRITE command then follows straight away, and the low strobe of the new preamble takes the place of the old postamble.

Top module: `ddr_wr_burst`

## Requirements
- R1: After reset the command pins drive NOP (select low, row, column and write strobes high), every output enable is low, and `req_ready` is high.
- R2: WRITE (select low, row strobe high, column strobe low, write strobe low) is driven in exactly the one cycle after a request is accepted (`req_valid` and `req_ready` both high at a rising clock edge). Every other cycle drives NOP.
- R3: In the WRITE cycle, `addr[8:0]` carries the column and `ba` carries the bank. All other address bits except bit 10 are zero, and address and bank are zero outside that cycle.
- R4: In the WRITE cycle, `addr[10]` equals the request's auto-precharge flag: 1 closes the row after the burst, 0 leaves it open.
- R5: Data word k sits at `req_data[16k+15:16k]`. In the first cycle after WRITE, `dq_rise` carries word 0 and `dq_fall` carries word 1. In the second cycle they carry words 2 and 3. `dq_oe` is high in exactly those two cycles.
- R6: Mask k sits at `req_mask[2k+1:2k]` and travels with word k on `dm_rise`/`dm_fall`. Bit 0 covers byte dq[7:0] and bit 1 covers dq[15:8]. A mask bit of 1 tells the memory to ignore that byte, and 0 lets it be written.
- R7: The strobe is enabled from the WRITE cycle through the postamble. It is low on both edges in the WRITE cycle (preamble), high on the rising edge and low on the falling edge in each data cycle, and low on both edges in the cycle after the last data cycle (postamble).
- R8: Once the postamble is over and no request is pending, `dq_oe` and `dqs_oe` drop to 0.
- R9: `req_ready` is low in the WRITE cycle and in every data cycle except the last. A request presented during those cycles is neither taken nor issued.
- R10: A request accepted in the last data cycle produces its WRITE in the next cycle. The strobe stays enabled and low there, and no separate postamble cycle appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Generator can take a request |
| req_bank | input | 2 | Target bank |
| req_col | input | 9 | Starting column |
| req_ap | input | 1 | Auto-precharge request |
| req_data | input | 64 | Four data words, word 0 lowest |
| req_mask | input | 8 | Four 2-bit byte masks, mask 0 lowest |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | 13 | Address pins |
| mem_ba | output | 2 | Bank pins |
| dq_rise | output | 16 | Data for rising edge |
| dq_fall | output | 16 | Data for falling edge |
| dq_oe | output | 1 | Data and mask output enable |
| dm_rise | output | 2 | Byte mask for rising edge |
| dm_fall | output | 2 | Byte mask for falling edge |
| dqs_rise | output | 1 | Strobe level for rising edge |
| dqs_fall | output | 1 | Strobe level for falling edge |
| dqs_oe | output | 1 | Strobe output enable |

## Verification
The function most likely to collide with the others is the acceptance of a new request in the last data cycle. In that same cycle the final two beats leave the block, so the end of one burst overlaps the start of the next. The bench provokes this by raising `req_valid` exactly while the second data cycle is on the outputs. It then requires that the second word pair is still correct in that cycle, that WRITE with the new address follows in the next cycle with the strobe held low, and that the second burst's data then follows with no postamble in between. A separate test raises the request one and two cycles too early and requires that no second command appears.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_POST = 2'd3
  } wr_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam ddr_cmd_t CMD_WRITE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};

  // Beat number carried in data cycle `cyc` on the given edge (0 rise, 1 fall).
  function automatic int unsigned beat_of(input int unsigned cyc, input bit fall_edge);
    return 2 * cyc + (fall_edge ? 1 : 0);
  endfunction

  // Number of clock cycles that a burst of `bl` beats occupies.
  function automatic int unsigned data_cycles(input int unsigned bl);
    return bl / 2;
  endfunction

endpackage

// File: rtl/ddr_wr_seq.sv
module ddr_wr_seq
  import ddr_wr_pkg::*;
#(
  parameter int unsigned BL = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  output logic                  accept,
  output wr_state_e             state,
  output logic [$clog2(BL)-1:0] beat_cyc,
  output logic                  last_cyc
);
  localparam int unsigned CYCLES = data_cycles(BL);
  localparam int unsigned CNT_W  = $clog2(BL);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  wr_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last_cyc  = (state_q == ST_DATA) && (cnt_q == LAST);
  assign req_ready = (state_q == ST_IDLE) || (state_q == ST_POST) || last_cyc;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_CMD;
      ST_CMD: begin
        state_d = ST_DATA;
        cnt_d   = '0;
      end
      ST_DATA: begin
        if (cnt_q == LAST) state_d = accept ? ST_CMD : ST_POST;
        else               cnt_d   = cnt_q + 1'b1;
      end
      ST_POST: state_d = accept ? ST_CMD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state    = state_q;
  assign beat_cyc = cnt_q;
endmodule

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture #(
  parameter int unsigned BA_W  = 2,
  parameter int unsigned COL_W = 9,
  parameter int unsigned DQ_W  = 16,
  parameter int unsigned BL    = 4,
  localparam int unsigned LANES = DQ_W / 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accept,
  input  logic [BA_W-1:0]             in_bank,
  input  logic [COL_W-1:0]            in_col,
  input  logic                        in_ap,
  input  logic [BL*DQ_W-1:0]          in_data,
  input  logic [BL*LANES-1:0]         in_mask,
  output logic [BA_W-1:0]             bank_q,
  output logic [COL_W-1:0]            col_q,
  output logic                        ap_q,
  output logic [BL-1:0][DQ_W-1:0]     data_q,
  output logic [BL-1:0][LANES-1:0]    mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
    end else if (accept) begin
      bank_q <= in_bank;
      col_q  <= in_col;
      ap_q   <= in_ap;
    end
  end

  for (genvar b = 0; b < BL; b++) begin : g_beat
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[b] <= '0;
        mask_q[b] <= '0;
      end else if (accept) begin
        data_q[b] <= in_data[b*DQ_W +: DQ_W];
        mask_q[b] <= in_mask[b*LANES +: LANES];
      end
    end
  end
endmodule

// File: rtl/ddr_wr_cmd.sv
module ddr_wr_cmd
  import ddr_wr_pkg::*;
#(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned AP_BIT = 10
) (
  input  wr_state_e          state,
  input  logic [BA_W-1:0]    bank_q,
  input  logic [COL_W-1:0]   col_q,
  input  logic               ap_q,
  output ddr_cmd_t           cmd,
  output logic [ADDR_W-1:0]  addr,
  output logic [BA_W-1:0]    ba
);
  logic issue;
  assign issue = (state == ST_CMD);

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    if (issue) begin
      cmd               = CMD_WRITE;
      addr[COL_W-1:0]   = col_q;
      addr[AP_BIT]      = ap_q;
      ba                = bank_q;
    end
  end
endmodule

// File: rtl/ddr_wr_lanes.sv
module ddr_wr_lanes
  import ddr_wr_pkg::*;
#(
  parameter int unsigned DQ_W = 16,
  parameter int unsigned BL   = 4,
  localparam int unsigned LANES = DQ_W / 8,
  localparam int unsigned IDX_W = $clog2(BL)
) (
  input  wr_state_e                 state,
  input  logic [IDX_W-1:0]          beat_cyc,
  input  logic [BL-1:0][DQ_W-1:0]   data_q,
  input  logic [BL-1:0][LANES-1:0]  mask_q,
  output logic [DQ_W-1:0]           dq_rise,
  output logic [DQ_W-1:0]           dq_fall,
  output logic [LANES-1:0]          dm_rise,
  output logic [LANES-1:0]          dm_fall,
  output logic                      dq_oe,
  output logic                      dqs_rise,
  output logic                      dqs_fall,
  output logic                      dqs_oe
);
  logic [IDX_W-1:0] rise_idx, fall_idx;
  assign rise_idx = IDX_W'(beat_of(int'(beat_cyc), 1'b0));
  assign fall_idx = IDX_W'(beat_of(int'(beat_cyc), 1'b1));

  always_comb begin
    dq_rise  = '0;
    dq_fall  = '0;
    dm_rise  = '0;
    dm_fall  = '0;
    dq_oe    = 1'b0;
    dqs_rise = 1'b0;
    dqs_fall = 1'b0;
    dqs_oe   = 1'b0;
    case (state)
      ST_CMD:  dqs_oe = 1'b1;
      ST_DATA: begin
        dqs_oe   = 1'b1;
        dqs_rise = 1'b1;
        dq_oe    = 1'b1;
        dq_rise  = data_q[rise_idx];
        dq_fall  = data_q[fall_idx];
        dm_rise  = mask_q[rise_idx];
        dm_fall  = mask_q[fall_idx];
      end
      ST_POST: dqs_oe = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_wr_burst.sv
module ddr_wr_burst
  import ddr_wr_pkg::*;
#(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned AP_BIT = 10,
  parameter int unsigned DQ_W   = 16,
  parameter int unsigned BL     = 4,
  localparam int unsigned LANES = DQ_W / 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [BA_W-1:0]          req_bank,
  input  logic [COL_W-1:0]         req_col,
  input  logic                     req_ap,
  input  logic [BL*DQ_W-1:0]       req_data,
  input  logic [BL*LANES-1:0]      req_mask,
  output logic                     mem_cs_n,
  output logic                     mem_ras_n,
  output logic                     mem_cas_n,
  output logic                     mem_we_n,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [BA_W-1:0]          mem_ba,
  output logic [DQ_W-1:0]          dq_rise,
  output logic [DQ_W-1:0]          dq_fall,
  output logic                     dq_oe,
  output logic [LANES-1:0]         dm_rise,
  output logic [LANES-1:0]         dm_fall,
  output logic                     dqs_rise,
  output logic                     dqs_fall,
  output logic                     dqs_oe
);
  localparam int unsigned IDX_W = $clog2(BL);

  // Internal events brought out by name for the checker.
  logic                     accept;
  logic                     last_cyc;
  wr_state_e                state;
  logic [IDX_W-1:0]         beat_cyc;
  logic [BA_W-1:0]          bank_q;
  logic [COL_W-1:0]         col_q;
  logic                     ap_q;
  logic [BL-1:0][DQ_W-1:0]  data_q;
  logic [BL-1:0][LANES-1:0] mask_q;
  ddr_cmd_t                 cmd;

  ddr_wr_seq #(.BL(BL)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .state(state), .beat_cyc(beat_cyc), .last_cyc(last_cyc)
  );

  ddr_wr_capture #(.BA_W(BA_W), .COL_W(COL_W), .DQ_W(DQ_W), .BL(BL)) u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .in_bank(req_bank), .in_col(req_col), .in_ap(req_ap),
    .in_data(req_data), .in_mask(req_mask),
    .bank_q(bank_q), .col_q(col_q), .ap_q(ap_q), .data_q(data_q), .mask_q(mask_q)
  );

  ddr_wr_cmd #(.BA_W(BA_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_cmd (
    .state(state), .bank_q(bank_q), .col_q(col_q), .ap_q(ap_q),
    .cmd(cmd), .addr(mem_addr), .ba(mem_ba)
  );

  ddr_wr_lanes #(.DQ_W(DQ_W), .BL(BL)) u_lanes (
    .state(state), .beat_cyc(beat_cyc), .data_q(data_q), .mask_q(mask_q),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall),
    .dq_oe(dq_oe), .dqs_rise(dqs_rise), .dqs_fall(dqs_fall), .dqs_oe(dqs_oe)
  );

  assign mem_cs_n  = cmd.cs_n;
  assign mem_ras_n = cmd.ras_n;
  assign mem_cas_n = cmd.cas_n;
  assign mem_we_n  = cmd.we_n;
endmodule

// File: rtl/ddr_wr_burst_chk.sv
module ddr_wr_burst_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_ap,
  input logic              accept,
  input logic              last_cyc,
  input logic              mem_cs_n,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dq_oe,
  input logic              dqs_rise,
  input logic              dqs_fall,
  input logic              dqs_oe
);
  logic is_wr;
  assign is_wr = !mem_cs_n && mem_ras_n && !mem_cas_n && !mem_we_n;

  // R2
  write_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> is_wr);

  // R2
  write_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> $past(accept));

  // R4
  ap_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> (mem_addr[AP_BIT] == $past(req_ap)));

  // R5
  strobe_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqs_oe && dqs_rise && !dqs_fall));

  // R7
  preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(dqs_oe && !dqs_rise && !dqs_fall));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dqs_oe |-> !dq_oe);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> !req_ready);

  // R10
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && accept) |=> (is_wr && dqs_oe && !dqs_rise && !dqs_fall));
endmodule

bind ddr_wr_burst ddr_wr_burst_chk #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_ap(req_ap), .accept(accept), .last_cyc(last_cyc),
  .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
  .mem_addr(mem_addr), .dq_oe(dq_oe), .dqs_rise(dqs_rise), .dqs_fall(dqs_fall),
  .dqs_oe(dqs_oe)
);

// File: tb/tb_ddr_wr_burst.sv
`timescale 1ns/1ps
module tb_ddr_wr_burst;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [8:0]  req_col = '0;
  logic        req_ap = 1'b0;
  logic [63:0] req_data = '0;
  logic [7:0]  req_mask = '0;
  logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [12:0] mem_addr;
  logic [1:0]  mem_ba;
  logic [15:0] dq_rise, dq_fall;
  logic        dq_oe;
  logic [1:0]  dm_rise, dm_fall;
  logic        dqs_rise, dqs_fall, dqs_oe;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  ddr_wr_burst dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap),
    .req_data(req_data), .req_mask(req_mask),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_ba(mem_ba), .dq_rise(dq_rise), .dq_fall(dq_fall),
    .dq_oe(dq_oe), .dm_rise(dm_rise), .dm_fall(dm_fall),
    .dqs_rise(dqs_rise), .dqs_fall(dqs_fall), .dqs_oe(dqs_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] cmd_bits();
    return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
  endfunction

  // Called at a falling edge inside the cycle in question.
  task automatic expect_nop_idle(input string tag);
    chk({"R1 nop ", tag}, 64'(cmd_bits()), 64'(4'b0111));
    chk({"R8 dq_oe ", tag}, 64'(dq_oe), 64'd0);
    chk({"R8 dqs_oe ", tag}, 64'(dqs_oe), 64'd0);
    chk({"R1 ready ", tag}, 64'(req_ready), 64'd1);
  endtask

  task automatic expect_write(input logic [1:0] bank, input logic [8:0] col, input logic ap);
    logic [12:0] exp_addr;
    exp_addr = '0;
    exp_addr[8:0] = col;
    exp_addr[10]  = ap;
    chk("R2 write code", 64'(cmd_bits()), 64'(4'b0100));
    chk("R3 address", 64'(mem_addr), 64'(exp_addr));
    chk("R3 bank", 64'(mem_ba), 64'(bank));
    chk("R4 ap bit", 64'(mem_addr[10]), 64'(ap));
    chk("R7 preamble", 64'({dqs_oe, dqs_rise, dqs_fall}), 64'(3'b100));
    chk("R5 no data in cmd cycle", 64'(dq_oe), 64'd0);
    chk("R9 ready low in cmd", 64'(req_ready), 64'd0);
  endtask

  task automatic expect_beats(input int cyc, input logic [63:0] d, input logic [7:0] m);
    int r;
    r = 2 * cyc;
    chk("R2 nop in data", 64'(cmd_bits()), 64'(4'b0111));
    chk("R3 addr zero", 64'(mem_addr), 64'd0);
    chk("R5 dq_oe", 64'(dq_oe), 64'd1);
    chk("R5 dq_rise", 64'(dq_rise), 64'(d[r*16 +: 16]));
    chk("R5 dq_fall", 64'(dq_fall), 64'(d[(r+1)*16 +: 16]));
    chk("R6 dm_rise", 64'(dm_rise), 64'(m[r*2 +: 2]));
    chk("R6 dm_fall", 64'(dm_fall), 64'(m[(r+1)*2 +: 2]));
    chk("R7 strobe toggles", 64'({dqs_oe, dqs_rise, dqs_fall}), 64'(3'b110));
    chk("R9 ready", 64'(req_ready), 64'(cyc == 1));
  endtask

  task automatic expect_post();
    chk("R2 nop in post", 64'(cmd_bits()), 64'(4'b0111));
    chk("R7 postamble", 64'({dqs_oe, dqs_rise, dqs_fall}), 64'(3'b100));
    chk("R8 data released in post", 64'(dq_oe), 64'd0);
  endtask

  task automatic present(input logic [1:0] b, input logic [8:0] c, input logic ap,
                         input logic [63:0] d, input logic [7:0] m);
    req_bank = b; req_col = c; req_ap = ap; req_data = d; req_mask = m;
    req_valid = 1'b1;
  endtask

  // One isolated burst: present at a falling edge, check every cycle.
  task automatic run_single(input logic [1:0] b, input logic [8:0] c, input logic ap,
                            input logic [63:0] d, input logic [7:0] m);
    @(negedge clk);
    present(b, c, ap, d, m);
    @(negedge clk);
    req_valid = 1'b0;
    req_data  = ~d;
    expect_write(b, c, ap);
    @(negedge clk); expect_beats(0, d, m);
    @(negedge clk); expect_beats(1, d, m);
    @(negedge clk); expect_post();
    @(negedge clk); expect_nop_idle("after burst");
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_nop_idle("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_nop_idle("after reset");
  endtask

  task automatic t_open_row();
    run_single(2'd1, 9'h1A5, 1'b0, 64'h4444_3333_2222_1111, 8'h00);
  endtask

  task automatic t_autoprecharge();
    run_single(2'd3, 9'h0FF, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, 8'h00);
  endtask

  task automatic t_masks();
    // R6: per-beat masks 00,11,10,01 for words 0..3
    run_single(2'd2, 9'h003, 1'b0, 64'h8899_6677_4455_2233, 8'b01_10_11_00);
    run_single(2'd0, 9'h100, 1'b1, 64'hFFFF_0000_A5A5_5A5A, 8'b11_00_01_10);
  endtask

  task automatic t_busy_ignored();
    logic [63:0] d;
    d = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    present(2'd1, 9'h055, 1'b0, d, 8'h0F);
    @(negedge clk);
    expect_write(2'd1, 9'h055, 1'b0);
    // R9: hold a different request while busy
    present(2'd2, 9'h1FF, 1'b1, 64'h1111_2222_3333_4444, 8'hFF);
    @(negedge clk);
    expect_beats(0, d, 8'h0F);
    req_valid = 1'b0;
    @(negedge clk);
    expect_beats(1, d, 8'h0F);
    @(negedge clk);
    expect_post();
    chk("R9 busy request not issued", 64'(mem_ba), 64'd0);
    @(negedge clk);
    expect_nop_idle("R9 after ignored request");
  endtask

  task automatic t_back_to_back();
    logic [63:0] d1, d2;
    logic [7:0]  m1, m2;
    d1 = 64'hAAAA_BBBB_CCCC_DDDD; m1 = 8'b00_01_10_11;
    d2 = 64'h1357_2468_9ABC_DEF0; m2 = 8'b10_10_01_01;
    @(negedge clk);
    present(2'd0, 9'h010, 1'b0, d1, m1);
    @(negedge clk);
    req_valid = 1'b0;
    expect_write(2'd0, 9'h010, 1'b0);
    @(negedge clk); expect_beats(0, d1, m1);
    @(negedge clk);
    present(2'd3, 9'h1C0, 1'b1, d2, m2);
    expect_beats(1, d1, m1);
    @(negedge clk);
    req_valid = 1'b0;
    // R10: new WRITE, strobe held low, no postamble cycle
    expect_write(2'd3, 9'h1C0, 1'b1);
    chk("R10 strobe stays enabled", 64'(dqs_oe), 64'd1);
    @(negedge clk); expect_beats(0, d2, m2);
    @(negedge clk); expect_beats(1, d2, m2);
    @(negedge clk); expect_post();
    @(negedge clk); expect_nop_idle("R10 after second burst");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_open_row();
    t_autoprecharge();
    t_masks();
    t_busy_ignored();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule